// File: doc/BRIEF.md
# Ping-Pong Posted Write Buffer

This block sits behind an AHB slave port and absorbs CPU write traffic aimed at one user-side target. It holds two 16-word (64-byte) buffers. The CPU fills one while the user logic drains the other, so a posted write completes on the bus without waiting for the target. Byte, halfword and word writes are packed into 32-bit words that carry per-byte enables. Incrementing bursts, early termination and BUSY beats need no special handling.

Writes that land in the same word, or in the next word, gather into one open command. The command closes on a bus pause, on a jump in address, or when it would need a seventeenth word. A closed buffer is offered to the user side as one command: a word-aligned start address, then a stream of data words with enables, and a flag on the final word. The buffers are used in strict alternation. HREADY is pulled low only when a write needs a fresh buffer and neither buffer is free.

Top module: `wpost_buf`

## Requirements
- R1: While `hresetn` is low, `u_valid` is 0 and `hready_out` is 1. After reset both buffers are empty.
- R2: Byte enables use little-endian lanes, with lane k on data bits [8k+7:8k]. A byte write (`hsize`=0) sets bit `haddr[1:0]`. A halfword write (`hsize`=1) sets 4'b0011 when `haddr[1]`=0 and 4'b1100 when it is 1. A word write (`hsize`=2) sets 4'b1111.
- R3: Writes to the same 32-bit word while its command is open fold into one user word. The enables are ORed and later data replaces earlier data in shared lanes. Data bytes whose enable is 0 are undefined.
- R4: `hready_out` is 1 in every cycle with no selected NONSEQ/SEQ write. It is also 1 for a write that continues the open command, or that starts a command while the next buffer in turn is free. A burst of up to 16 words into a free buffer therefore has zero wait states.
- R5: A command holds at most 16 words. A contiguous write that needs a seventeenth word starts a new command whose start address is that word's address.
- R6: A BUSY transfer (`htrans`=2'b01) with `hsel` high writes nothing, does not advance the word position and does not close the open command.
- R7: An IDLE transfer, a read, or a cycle with `hsel` low closes the open command. A write (`htrans` NONSEQ=2'b10 or SEQ=2'b11) whose word is neither the last written word nor the one after it starts a new command.
- R8: `hready_out` is 0 only while a write needs a new buffer and that buffer still holds an undrained command. The write is taken once the user side has accepted the final word of that command.
- R9: A command appears on `u_addr` as its word-aligned start address. Its words follow in ascending order with `u_last` set on the final one. While `u_valid` is 1 and `u_ready` is 0, all user-side outputs hold.
- R10: Commands reach the user side in the order they were posted. Within a command, `u_valid` stays high until the final word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 for write |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| haddr | input | AW | Byte address of the address phase |
| hwdata | input | 32 | Write data of the data phase |
| hready_out | output | 1 | Low to stall the bus when no buffer is free |
| u_valid | output | 1 | A user-side word is offered |
| u_ready | input | 1 | User logic accepts the offered word |
| u_addr | output | AW | Start address of the current command |
| u_data | output | 32 | Offered data word |
| u_be | output | 4 | Byte enables of the offered word |
| u_last | output | 1 | Offered word is the command's final word |

## Verification
The bench builds the block with its defaults, AW=32 and WORDS=16. At that depth a 17-word burst crosses the command limit exactly once, and two back-to-back posts fill both buffers within a few cycles. Narrow random bursts cross word boundaries and land inside partly written words. The user side is held off, freed or throttled at random, so stalls, the alternation between buffers and merging within a word are all reached.

// File: rtl/wpost_buf.sv
module wpost_buf #(
  parameter int AW    = 32,
  parameter int WORDS = 16,
  localparam int IW   = $clog2(WORDS),
  localparam int WA   = AW - 2
) (
  input  logic          hclk,
  input  logic          hresetn,
  input  logic          hsel,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [2:0]    hsize,
  input  logic [AW-1:0] haddr,
  input  logic [31:0]   hwdata,
  output logic          hready_out,
  output logic          u_valid,
  input  logic          u_ready,
  output logic [AW-1:0] u_addr,
  output logic [31:0]   u_data,
  output logic [3:0]    u_be,
  output logic          u_last
);

  logic [31:0]   mem  [2][WORDS];
  logic [3:0]    bem  [2][WORDS];
  logic [WA-1:0] base [2];
  logic [IW-1:0] cnt  [2];

  logic [1:0]    full;
  logic          fsel, dsel, open;
  logic [WA-1:0] lastw;
  logic [IW-1:0] widx, rptr;
  logic          dp_v, dp_b;
  logic [IW-1:0] dp_i;
  logic [3:0]    dp_be;
  logic [3:0]    lane;

  wire [WA-1:0] w     = haddr[AW-1:2];
  wire          xfer  = hsel && htrans[1] && hwrite;
  wire          hold  = hsel && (htrans == 2'b01);
  wire          same  = open && (w == lastw);
  wire          nxt   = open && (w == lastw + 1'b1) && (widx != IW'(WORDS - 1));
  wire          fresh = xfer && !same && !nxt;
  wire          tgt   = open ? ~fsel : fsel;
  wire          stall = fresh && full[tgt];
  wire          take  = xfer && !stall;
  wire          close = open && (fresh || (!xfer && !hold));
  wire          rel   = u_valid && u_ready && u_last;

  assign hready_out = !stall;
  assign u_valid    = full[dsel];
  assign u_addr     = {base[dsel], 2'b00};
  assign u_data     = mem[dsel][rptr];
  assign u_be       = bem[dsel][rptr];
  assign u_last     = (rptr == cnt[dsel]);

  always_comb begin
    case (hsize)
      3'd0:    lane = 4'b0001 << haddr[1:0];
      3'd1:    lane = haddr[1] ? 4'b1100 : 4'b0011;
      default: lane = 4'b1111;
    endcase
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      full  <= '0;
      fsel  <= 1'b0;
      dsel  <= 1'b0;
      open  <= 1'b0;
      lastw <= '0;
      widx  <= '0;
      rptr  <= '0;
      dp_v  <= 1'b0;
      dp_b  <= 1'b0;
      dp_i  <= '0;
      dp_be <= '0;
    end else begin
      dp_v <= take;
      if (take) begin
        dp_be <= lane;
        lastw <= w;
        if (fresh) begin
          dp_b <= tgt;
          dp_i <= '0;
          widx <= '0;
        end else if (nxt) begin
          dp_b <= fsel;
          dp_i <= widx + 1'b1;
          widx <= widx + 1'b1;
        end else begin
          dp_b <= fsel;
          dp_i <= widx;
        end
      end
      if (close) begin
        fsel <= ~fsel;
        open <= take;
      end else if (take) begin
        open <= 1'b1;
      end
      full <= (full | (close ? (2'b01 << fsel) : 2'b00))
                    & ~(rel ? (2'b01 << dsel) : 2'b00);
      if (rel) begin
        rptr <= '0;
        dsel <= ~dsel;
      end else if (u_valid && u_ready) begin
        rptr <= rptr + 1'b1;
      end
    end
  end

  always_ff @(posedge hclk) begin
    if (take && fresh) begin
      base[tgt]   <= w;
      cnt[tgt]    <= '0;
      bem[tgt][0] <= '0;
    end
    if (take && nxt) begin
      cnt[fsel]             <= widx + 1'b1;
      bem[fsel][widx + 1'b1] <= '0;
    end
    if (dp_v) begin
      for (int k = 0; k < 4; k++)
        if (dp_be[k]) mem[dp_b][dp_i][8*k +: 8] <= hwdata[8*k +: 8];
      bem[dp_b][dp_i] <= bem[dp_b][dp_i] | dp_be;
    end
  end

endmodule

// File: rtl/wpost_buf_chk.sv
module wpost_buf_chk #(
  parameter int AW = 32
) (
  input logic          hclk,
  input logic          hresetn,
  input logic          hsel,
  input logic [1:0]    htrans,
  input logic          hready_out,
  input logic          u_valid,
  input logic          u_ready,
  input logic [AW-1:0] u_addr,
  input logic [31:0]   u_data,
  input logic [3:0]    u_be,
  input logic          u_last
);

  wire [31:0] mask = {{8{u_be[3]}}, {8{u_be[2]}}, {8{u_be[1]}}, {8{u_be[0]}}};

  assert_quiet_reset_R1: assert property (@(posedge hclk)
    !hresetn |-> (!u_valid && hready_out));

  assert_idle_ready_R4: assert property (@(posedge hclk) disable iff (!hresetn)
    (!hsel || htrans == 2'b00) |-> hready_out);

  assert_stall_cause_R8: assert property (@(posedge hclk) disable iff (!hresetn)
    !hready_out |-> u_valid);

  assert_hold_out_R9: assert property (@(posedge hclk) disable iff (!hresetn)
    (u_valid && !u_ready) |=> (u_valid && $stable(u_addr) && $stable(u_be)
                               && $stable(u_last) && $stable(u_data & mask)));

  assert_no_early_release_R10: assert property (@(posedge hclk) disable iff (!hresetn)
    (u_valid && u_ready && !u_last) |=> u_valid);

endmodule

bind wpost_buf wpost_buf_chk #(.AW(AW)) i_chk (
  .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans),
  .hready_out(hready_out), .u_valid(u_valid), .u_ready(u_ready),
  .u_addr(u_addr), .u_data(u_data), .u_be(u_be), .u_last(u_last)
);

// File: tb/test_wpost_buf.sv
module test_wpost_buf;
  logic        hclk = 1'b0, hresetn = 1'b0;
  logic        hsel = 1'b0, hwrite = 1'b0, u_ready = 1'b0;
  logic [1:0]  htrans = 2'b00;
  logic [2:0]  hsize = 3'd0;
  logic [31:0] haddr = '0, hwdata = '0;
  logic        hready_out, u_valid, u_last;
  logic [31:0] u_addr, u_data;
  logic [3:0]  u_be;

  always #10 hclk = ~hclk;

  wpost_buf i_wpost_buf (.*);

  int checks = 0, fails = 0, stalls = 0, cmds = 0, words = 0, rdy_mode = 1;
  string tag = "R1";
  logic [31:0] last_cmd_addr = '0, pend = '0;
  logic [3:0]  last_be = '0;

  logic [31:0] q_addr[$], q_data[$];
  logic [3:0]  q_be[$];
  bit          q_last[$];

  bit          m_open = 0;
  logic [29:0] m_last, m_base;
  int          m_cnt = 0;
  logic [31:0] m_d[16];
  logic [3:0]  m_b[16];

  function automatic logic [3:0] lanes(logic [2:0] s, logic [1:0] a);
    if (s == 3'd0) return 4'b0001 << a;
    if (s == 3'd1) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] bmask(logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void m_close();
    for (int i = 0; i < m_cnt; i++) begin
      q_addr.push_back({m_base, 2'b00});
      q_data.push_back(m_d[i]);
      q_be.push_back(m_b[i]);
      q_last.push_back(i == m_cnt - 1);
    end
    m_open = 0;
  endfunction

  function automatic void m_pre(bit sel, logic [1:0] tr, bit wr, logic [31:0] a);
    if (sel && tr[1] && wr) begin
      if (m_open && !(a[31:2] == m_last || (a[31:2] == m_last + 1 && m_cnt < 16))) m_close();
    end else if (!(sel && tr == 2'b01)) begin
      if (m_open) m_close();
    end
  endfunction

  function automatic void m_acc(bit sel, logic [1:0] tr, bit wr, logic [31:0] a,
                                logic [2:0] s, logic [31:0] d);
    logic [3:0] be;
    if (!(sel && tr[1] && wr)) return;
    if (!m_open) begin
      m_open = 1; m_base = a[31:2]; m_last = a[31:2]; m_cnt = 1; m_b[0] = '0;
    end else if (a[31:2] != m_last) begin
      m_cnt++; m_b[m_cnt-1] = '0; m_last = a[31:2];
    end
    be = lanes(s, a[1:0]);
    m_d[m_cnt-1] = (m_d[m_cnt-1] & ~bmask(be)) | (d & bmask(be));
    m_b[m_cnt-1] = m_b[m_cnt-1] | be;
  endfunction

  task automatic issue(bit sel, logic [1:0] tr, bit wr, logic [31:0] a,
                       logic [2:0] s, logic [31:0] d);
    @(negedge hclk);
    hsel = sel; htrans = tr; hwrite = wr; haddr = a; hsize = s; hwdata = pend;
    m_pre(sel, tr, wr, a);
    forever begin
      #8;
      if (hready_out) break;
      stalls++;
      @(negedge hclk);
    end
    @(posedge hclk);
    m_acc(sel, tr, wr, a, s, d);
    pend = (sel && tr[1] && wr) ? d : $urandom;
  endtask

  task automatic idle();
    issue(1'b0, 2'b00, 1'b0, 32'h0, 3'd0, 32'h0);
  endtask

  task automatic drain();
    rdy_mode = 1;
    while (q_addr.size() != 0) @(posedge hclk);
    repeat (3) @(posedge hclk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge hclk);
      u_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'($urandom % 2) : 1'b0;
      #8;
      if (hresetn && u_valid && u_ready) begin
        words++;
        last_be = u_be;
        if (u_last) begin cmds++; last_cmd_addr = u_addr; end
        if (q_addr.size() == 0) begin
          check(0, tag, "unexpected user word addr", u_addr, 32'h0);
        end else begin
          check(u_addr == q_addr[0], tag, "start address", u_addr, q_addr[0]);
          check(u_be == q_be[0], tag, "byte enables", {28'h0, u_be}, {28'h0, q_be[0]});
          check((u_data & bmask(q_be[0])) == (q_data[0] & bmask(q_be[0])), tag, "data",
                u_data & bmask(q_be[0]), q_data[0] & bmask(q_be[0]));
          check(u_last == q_last[0], tag, "last flag", {31'h0, u_last}, {31'h0, q_last[0]});
          void'(q_addr.pop_front()); void'(q_data.pop_front());
          void'(q_be.pop_front());   void'(q_last.pop_front());
        end
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge hclk);
    check(0, "R10", "watchdog expired", 32'h0, 32'h1);
    report();
  end

  initial begin : stim
    int c0, w0, s0;
    logic [31:0] d0, d1;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge hclk);
    @(negedge hclk); #8;
    check(u_valid == 1'b0, "R1", "u_valid in reset", {31'h0, u_valid}, 32'h0);
    check(hready_out == 1'b1, "R1", "hready_out in reset", {31'h0, hready_out}, 32'h1);
    @(negedge hclk); hresetn = 1'b1;

    tag = "R2"; c0 = cmds;
    issue(1, 2'b10, 1, 32'h102, 3'd0, 32'hAABBCCDD);
    issue(1, 2'b10, 1, 32'h100, 3'd1, 32'h11223344);
    idle(); drain();
    check(cmds == c0 + 1, "R3", "merged commands", cmds - c0, 1);
    check(last_be == 4'b0111, "R2", "merged enables", {28'h0, last_be}, 32'h7);

    tag = "R5"; c0 = cmds; w0 = words; s0 = stalls;
    for (int i = 0; i < 17; i++)
      issue(1, i == 0 ? 2'b10 : 2'b11, 1, 32'h200 + 4 * i, 3'd2, $urandom);
    idle();
    check(stalls == s0, "R4", "wait states in free buffer", stalls - s0, 0);
    drain();
    check(cmds == c0 + 2, "R5", "commands for 17 words", cmds - c0, 2);
    check(words == w0 + 17, "R5", "words delivered", words - w0, 17);
    check(last_cmd_addr == 32'h240, "R5", "second start address", last_cmd_addr, 32'h240);

    tag = "R6"; c0 = cmds; w0 = words;
    issue(1, 2'b10, 1, 32'h300, 3'd2, 32'h01010101);
    issue(1, 2'b11, 1, 32'h304, 3'd2, 32'h02020202);
    issue(1, 2'b01, 1, 32'h308, 3'd2, 32'hDEADBEEF);
    issue(1, 2'b01, 1, 32'h308, 3'd2, 32'hDEADBEEF);
    issue(1, 2'b11, 1, 32'h308, 3'd2, 32'h03030303);
    issue(1, 2'b11, 1, 32'h30C, 3'd2, 32'h04040404);
    idle(); drain();
    check(cmds == c0 + 1, "R6", "BUSY kept command open", cmds - c0, 1);
    check(words == w0 + 4, "R6", "BUSY added no word", words - w0, 4);

    tag = "R7"; c0 = cmds;
    issue(1, 2'b10, 1, 32'h400, 3'd2, $urandom);
    issue(1, 2'b10, 1, 32'h40C, 3'd2, $urandom);
    issue(1, 2'b11, 1, 32'h410, 3'd2, $urandom);
    issue(1, 2'b10, 0, 32'h500, 3'd2, 32'h0);
    issue(1, 2'b10, 1, 32'h600, 3'd0, $urandom);
    issue(0, 2'b10, 1, 32'h604, 3'd0, 32'h0);
    drain();
    check(cmds == c0 + 3, "R7", "commands after closes", cmds - c0, 3);
    check(last_cmd_addr == 32'h600, "R7", "last start address", last_cmd_addr, 32'h600);

    tag = "R8"; c0 = cmds; s0 = stalls; rdy_mode = 0;
    issue(1, 2'b10, 1, 32'h700, 3'd2, $urandom);
    idle();
    issue(1, 2'b10, 1, 32'h800, 3'd2, $urandom);
    idle();
    check(stalls == s0, "R8", "two posts without wait", stalls - s0, 0);
    @(negedge hclk);
    hsel = 1; htrans = 2'b10; hwrite = 1; haddr = 32'h900; hsize = 3'd2; hwdata = pend;
    #8;
    check(hready_out == 1'b0, "R8", "stall with both buffers full", {31'h0, hready_out}, 32'h0);
    d0 = u_data & bmask(u_be);
    repeat (2) @(negedge hclk);
    #8;
    check(hready_out == 1'b0, "R8", "stall persists", {31'h0, hready_out}, 32'h0);
    check(u_addr == 32'h700, "R10", "oldest command first", u_addr, 32'h700);
    d1 = u_data & bmask(u_be);
    check(d1 == d0, "R9", "held data stable", d1, d0);
    @(posedge hclk);
    rdy_mode = 1;
    issue(1, 2'b10, 1, 32'h900, 3'd2, $urandom);
    idle(); drain();
    check(cmds == c0 + 3, "R10", "all three delivered", cmds - c0, 3);
    check(last_cmd_addr == 32'h900, "R10", "posting order", last_cmd_addr, 32'h900);

    tag = "R9"; rdy_mode = 2;
    for (int b = 0; b < 60; b++) begin
      logic [2:0]  s;
      logic [31:0] a;
      int n, r;
      s = 3'($urandom % 3);
      a = (32'h1000 + ($urandom % 256)) & ~((32'h1 << s) - 1);
      n = 1 + $urandom % 20;
      for (int i = 0; i < n; i++) begin
        if (i > 0 && $urandom % 7 == 0) issue(1, 2'b01, 1, a, s, $urandom);
        issue(1, i == 0 ? 2'b10 : 2'b11, 1, a, s, $urandom);
        a = a + (32'h1 << s);
      end
      r = $urandom % 10;
      if (r < 3) idle();
      else if (r == 3) issue(1, 2'b10, 0, 32'h2000, 3'd2, 32'h0);
      else if (r == 4) issue(0, 2'b10, 1, 32'h2000, 3'd2, 32'h0);
      rdy_mode = 2;
    end
    idle(); drain();
    check(q_addr.size() == 0, "R10", "expected words outstanding", q_addr.size(), 0);
    check(u_valid == 1'b0, "R10", "idle after drain", {31'h0, u_valid}, 32'h0);
    report();
  end
endmodule